// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is an SPI master that software drives through a 32-bit register port. Software queues a word in a small transmit FIFO and picks the word length, the clock polarity and the clock phase. It then writes a start bit in the command register. The shift engine clocks out the low (length+1) bits, most significant bit first. At the same time it gathers the same number of bits from the serial input and pushes them, right-aligned, into a receive FIFO.

Chip select is driven by software. A register field picks one of the select lines, a value bit asserts it and a polarity bit sets the asserted level. A status register reports FIFO levels and engine activity. It also holds sticky event flags, which software clears by writing ones. Writing ones to two action bits in the same register empties a FIFO at once.

Top module: `spi_regmap_master`

## Requirements
- R1: After reset the status register (offset 0x08) reads 0x00A00000, which means only RX-empty (bit 23) and TX-empty (bit 21) are set. Every chip-select output is high and SCLK is low.
- R2: The command register (0x00) reads back only the bits it stores: 31, 28, 25:24, 21, 13:11 and 4:0. The start bit (30) always reads 0. The command2 register (0x04) stores bits 31:30 and 19:17. Offsets 0x0C, 0x10, 0x14, 0x18 and 0x1C read as zero.
- R3: A command write with the enable bit (31) and the start bit (30) both set launches a word of L = bits[4:0]+1 bits. BSY (status bit 31) stays high until the word ends. SCLK makes exactly 2L transitions spaced DIV_N+1 clock cycles apart. It starts from and returns to the idle level given by command bit 24.
- R4: The transmitted bits are bits L-1..0 of the TX FIFO head, most significant first. The received word is right-aligned. With phase bit 21 at 0, MISO is sampled on the leading SCLK edge. With it at 1, MISO is sampled on the trailing edge.
- R5: At the end of a word BSY clears and RDY (bit 30) sets. If receive is enabled (command2 bit 31), the received word is pushed into the RX FIFO, which is read at offset 0x180.
- R6: A start request while BSY is high is ignored and sets ERR (bit 29).
- R7: Event flags RDY(30), ERR(29), RX overflow(25), TX underrun(24), TX overflow(19) and RX underrun(18) are sticky. Writing 1 to a flag clears it. Writing 0 leaves it unchanged.
- R8: The TX FIFO, written at offset 0x100, holds 4 words. TX-full (bit 20) is set at 4 entries. A write to a full TX FIFO is dropped and sets TX overflow.
- R9: A read of an empty RX FIFO returns 0 and sets RX underrun.
- R10: Writing 1 to status bit 27 empties the RX FIFO and writing 1 to bit 26 empties the TX FIFO. Both bits read back as 0.
- R11: When software select (command bit 11) and the value bit (bit 12) are both set, the line chosen by command2 bits 19:18 goes to the level of polarity bit 13. Every other line sits at the inverse of bit 13.
- R12: A start with transmit enabled (command2 bit 30) and an empty TX FIFO shifts out zeros and sets TX underrun. If the RX FIFO is full when a received word arrives, the word is dropped and RX overflow (bit 25) sets, while RX-full is bit 22.
- R13: With transmit disabled, a start shifts out zeros and leaves the TX FIFO untouched. With receive disabled, the received word is not pushed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_req_i | input | 1 | Register access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | 9 | Byte offset of the register |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after a read request |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_o | output | NUM_CS | Chip-select lines |

## Verification
A wrong shift-engine state shows on SCLK as an extra or missing transition, or a wrong spacing. It also shows as a captured word that differs from the queued word within that same transfer. It then shows again at the first RX FIFO read after BSY falls. A wrong FIFO pointer or count shows in the next status read, as a wrong full or empty bit. It also shows as a misordered word on the next RX read. An event flag that fails to set or to clear shows in the first status read after the causing access.

// File: rtl/spi_rm_pkg.sv
package spi_rm_pkg;
    localparam int unsigned ADDR_W = 9;
    localparam int unsigned DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CMD  = 9'h000;
    localparam logic [ADDR_W-1:0] OFF_CMD2 = 9'h004;
    localparam logic [ADDR_W-1:0] OFF_STAT = 9'h008;
    localparam logic [ADDR_W-1:0] OFF_TXF  = 9'h100;
    localparam logic [ADDR_W-1:0] OFF_RXF  = 9'h180;

    // command fields
    localparam int unsigned C_EN    = 31;
    localparam int unsigned C_GO    = 30;
    localparam int unsigned C_IDLE  = 24;
    localparam int unsigned C_PHASE = 21;
    localparam int unsigned C_POL   = 13;
    localparam int unsigned C_VAL   = 12;
    localparam int unsigned C_SOFT  = 11;
    localparam logic [DATA_W-1:0] CMD_KEEP  = 32'h9320_381F;
    // command2 fields
    localparam int unsigned C2_RX   = 31;
    localparam int unsigned C2_TX   = 30;
    localparam logic [DATA_W-1:0] CMD2_KEEP = 32'hC00E_0000;
    // status action bits
    localparam int unsigned S_RXFLUSH = 27;
    localparam int unsigned S_TXFLUSH = 26;

    typedef struct packed {
        logic rdy;
        logic err;
        logic rx_ovf;
        logic tx_unr;
        logic tx_ovf;
        logic rx_unr;
    } evt_t;
endpackage

// File: rtl/spi_rm_fifo.sv
module spi_rm_fifo #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] data_i,
    input  logic         pop_i,
    input  logic         flush_i,
    output logic [W-1:0] head_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
    localparam logic [CW-1:0] FULLC = CW'(DEPTH);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_pop, do_push;

    always_comb begin
        d       = q;
        do_pop  = pop_i && (q.cnt != '0);
        do_push = push_i && ((q.cnt != FULLC) || do_pop);
        if (flush_i) begin
            d.rp  = '0;
            d.wp  = '0;
            d.cnt = '0;
        end else begin
            if (do_push) begin
                d.mem[q.wp] = data_i;
                d.wp = (q.wp == LAST) ? '0 : q.wp + 1'b1;
            end
            if (do_pop) begin
                d.rp = (q.rp == LAST) ? '0 : q.rp + 1'b1;
            end
            d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head_o  = q.mem[q.rp];
    assign full_o  = (q.cnt == FULLC);
    assign empty_o = (q.cnt == '0);
endmodule

// File: rtl/spi_rm_shifter.sv
module spi_rm_shifter #(
    parameter int unsigned DIV_N = 3,
    parameter int unsigned MAXW  = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start_i,
    input  logic [$clog2(MAXW)-1:0]  len_i,
    input  logic                     cpol_i,
    input  logic                     cpha_i,
    input  logic [MAXW-1:0]          word_i,
    input  logic                     idle_lvl_i,
    input  logic                     miso_i,
    output logic                     sclk_o,
    output logic                     mosi_o,
    output logic                     busy_o,
    output logic                     done_o,
    output logic [MAXW-1:0]          rx_word_o
);
    localparam int unsigned LW = $clog2(MAXW);
    localparam int unsigned EW = LW + 2;
    localparam int unsigned DW = (DIV_N > 0) ? $clog2(DIV_N + 1) : 1;
    localparam logic [DW-1:0] DIV_TOP = DW'(DIV_N);

    typedef struct packed {
        logic            busy;
        logic [DW-1:0]   div;
        logic [EW-1:0]   edge_n;
        logic [LW-1:0]   len;
        logic            cpha;
        logic            sclk;
        logic [MAXW-1:0] tx;
        logic [MAXW-1:0] rx;
    } sh_st_t;

    sh_st_t q, d;
    logic [EW-1:0] last_edge;
    logic          sample_now;

    always_comb begin
        d          = q;
        done_o     = 1'b0;
        last_edge  = {1'b0, q.len, 1'b1};
        sample_now = (q.edge_n[0] == q.cpha);
        if (!q.busy) begin
            d.sclk = idle_lvl_i;
            if (start_i) begin
                d.busy   = 1'b1;
                d.div    = '0;
                d.edge_n = '0;
                d.len    = len_i;
                d.cpha   = cpha_i;
                d.sclk   = cpol_i;
                d.tx     = word_i;
                d.rx     = '0;
            end
        end else if (q.div == DIV_TOP) begin
            d.div    = '0;
            d.sclk   = ~q.sclk;
            d.edge_n = q.edge_n + 1'b1;
            if (sample_now)             d.rx = {q.rx[MAXW-2:0], miso_i};
            else if (q.edge_n != '0)    d.tx = q.tx << 1;
            if (q.edge_n == last_edge) begin
                d.busy = 1'b0;
                done_o = 1'b1;
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rx_word_o = d.rx;
    assign mosi_o    = q.tx[q.len];
    assign sclk_o    = q.sclk;
    assign busy_o    = q.busy;
endmodule

// File: rtl/spi_regmap_master.sv
module spi_regmap_master
    import spi_rm_pkg::*;
#(
    parameter int unsigned DIV_N      = 3,
    parameter int unsigned FIFO_DEPTH = 4,
    parameter int unsigned NUM_CS     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req_i,
    input  logic              bus_we_i,
    input  logic [8:0]        bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              sclk_o,
    output logic              mosi_o,
    input  logic              miso_i,
    output logic [NUM_CS-1:0] cs_o
);
    typedef struct packed {
        logic [DATA_W-1:0] cmd;
        logic [DATA_W-1:0] cmd2;
        evt_t              evt;
        logic [DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t q, d;

    logic              tx_push, tx_pop, tx_flush, tx_full, tx_empty;
    logic              rx_push, rx_pop, rx_flush, rx_full, rx_empty;
    logic [DATA_W-1:0] tx_head, rx_head, rx_word, sh_word;
    logic              sh_start, sh_busy, sh_done;
    logic              wr, rd;
    logic [DATA_W-1:0] stat_word;
    logic              flag_rdy, flag_err, flag_txovf, cfg_idle, cfg_cspol;

    always_comb begin
        stat_word     = '0;
        stat_word[31] = sh_busy;
        stat_word[30] = q.evt.rdy;
        stat_word[29] = q.evt.err;
        stat_word[25] = q.evt.rx_ovf;
        stat_word[24] = q.evt.tx_unr;
        stat_word[23] = rx_empty;
        stat_word[22] = rx_full;
        stat_word[21] = tx_empty;
        stat_word[20] = tx_full;
        stat_word[19] = q.evt.tx_ovf;
        stat_word[18] = q.evt.rx_unr;
    end

    always_comb begin
        d        = q;
        d.rdata  = '0;
        wr       = bus_req_i && bus_we_i;
        rd       = bus_req_i && !bus_we_i;
        tx_push  = 1'b0;
        tx_pop   = 1'b0;
        tx_flush = 1'b0;
        rx_pop   = 1'b0;
        rx_push  = 1'b0;
        rx_flush = 1'b0;
        sh_start = 1'b0;
        sh_word  = (q.cmd2[C2_TX] && !tx_empty) ? tx_head : '0;

        if (wr) begin
            unique case (bus_addr_i)
                OFF_CMD: begin
                    d.cmd = bus_wdata_i & CMD_KEEP;
                    if (bus_wdata_i[C_GO]) begin
                        if (sh_busy) begin
                            d.evt.err = 1'b1;
                        end else if (bus_wdata_i[C_EN]) begin
                            sh_start = 1'b1;
                            if (q.cmd2[C2_TX]) begin
                                if (tx_empty) d.evt.tx_unr = 1'b1;
                                else          tx_pop = 1'b1;
                            end
                        end
                    end
                end
                OFF_CMD2: d.cmd2 = bus_wdata_i & CMD2_KEEP;
                OFF_STAT: begin
                    d.evt    = q.evt & ~{bus_wdata_i[30], bus_wdata_i[29], bus_wdata_i[25],
                                         bus_wdata_i[24], bus_wdata_i[19], bus_wdata_i[18]};
                    tx_flush = bus_wdata_i[S_TXFLUSH];
                    rx_flush = bus_wdata_i[S_RXFLUSH];
                end
                OFF_TXF: begin
                    if (tx_full) d.evt.tx_ovf = 1'b1;
                    else         tx_push = 1'b1;
                end
                default: ;
            endcase
        end

        if (rd) begin
            unique case (bus_addr_i)
                OFF_CMD:  d.rdata = q.cmd;
                OFF_CMD2: d.rdata = q.cmd2;
                OFF_STAT: d.rdata = stat_word;
                OFF_RXF: begin
                    if (rx_empty) begin
                        d.evt.rx_unr = 1'b1;
                    end else begin
                        rx_pop  = 1'b1;
                        d.rdata = rx_head;
                    end
                end
                default: ;
            endcase
        end

        if (sh_done) begin
            d.evt.rdy = 1'b1;
            if (q.cmd2[C2_RX]) begin
                if (rx_full && !rx_pop) d.evt.rx_ovf = 1'b1;
                else                    rx_push = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    spi_rm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) txq_i (
        .clk(clk), .rst_n(rst_n), .push_i(tx_push), .data_i(bus_wdata_i),
        .pop_i(tx_pop), .flush_i(tx_flush), .head_o(tx_head),
        .full_o(tx_full), .empty_o(tx_empty)
    );

    spi_rm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) rxq_i (
        .clk(clk), .rst_n(rst_n), .push_i(rx_push), .data_i(rx_word),
        .pop_i(rx_pop), .flush_i(rx_flush), .head_o(rx_head),
        .full_o(rx_full), .empty_o(rx_empty)
    );

    spi_rm_shifter #(.DIV_N(DIV_N), .MAXW(DATA_W)) eng_i (
        .clk(clk), .rst_n(rst_n), .start_i(sh_start),
        .len_i(bus_wdata_i[4:0]), .cpol_i(bus_wdata_i[C_IDLE]),
        .cpha_i(bus_wdata_i[C_PHASE]), .word_i(sh_word),
        .idle_lvl_i(q.cmd[C_IDLE]), .miso_i(miso_i), .sclk_o(sclk_o),
        .mosi_o(mosi_o), .busy_o(sh_busy), .done_o(sh_done), .rx_word_o(rx_word)
    );

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        logic sel_hit;
        assign sel_hit = q.cmd[C_SOFT] && q.cmd[C_VAL] && (q.cmd2[19:18] == 2'(i));
        assign cs_o[i] = sel_hit ? q.cmd[C_POL] : ~q.cmd[C_POL];
    end

    assign bus_rdata_o = q.rdata;
    assign flag_rdy    = q.evt.rdy;
    assign flag_err    = q.evt.err;
    assign flag_txovf  = q.evt.tx_ovf;
    assign cfg_idle    = q.cmd[C_IDLE];
    assign cfg_cspol   = q.cmd[C_POL];
endmodule

// File: rtl/spi_rm_checker.sv
module spi_rm_checker #(
    parameter int unsigned NUM_CS = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req_i,
    input logic              bus_we_i,
    input logic [8:0]        bus_addr_i,
    input logic [31:0]       bus_wdata_i,
    input logic              sclk_o,
    input logic [NUM_CS-1:0] cs_o,
    input logic              busy,
    input logic              rdy,
    input logic              err,
    input logic              tx_full,
    input logic              tx_ovf,
    input logic              idle_lvl,
    input logic              cs_pol
);
    AST_END_SETS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> rdy); // R5

    AST_IDLE_SCLK_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && $stable(idle_lvl)) |-> (sclk_o == idle_lvl)); // R3

    AST_GO_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && bus_we_i && bus_addr_i == 9'h000 && bus_wdata_i[30] && busy) |=> err); // R6

    AST_TX_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_i && bus_we_i && bus_addr_i == 9'h100 && tx_full) |=> tx_ovf); // R8

    AST_ONE_CS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cs_o ^ {NUM_CS{~cs_pol}})); // R11
endmodule

bind spi_regmap_master spi_rm_checker #(.NUM_CS(NUM_CS)) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .sclk_o(sclk_o),
    .cs_o(cs_o), .busy(sh_busy), .rdy(flag_rdy), .err(flag_err),
    .tx_full(tx_full), .tx_ovf(flag_txovf), .idle_lvl(cfg_idle), .cs_pol(cfg_cspol)
);

// File: tb/spi_regmap_master_tb_top.sv
module spi_regmap_master_tb_top;
    localparam int unsigned DIV_N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req_i = 1'b0, bus_we_i = 1'b0;
    logic [8:0]  bus_addr_i = '0;
    logic [31:0] bus_wdata_i = '0, bus_rdata_o;
    logic        sclk_o, mosi_o;
    logic        miso_i = 1'b0;
    logic [1:0]  cs_o;

    always #4 clk = ~clk;

    spi_regmap_master #(.DIV_N(DIV_N), .FIFO_DEPTH(4), .NUM_CS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_req_i(bus_req_i), .bus_we_i(bus_we_i),
        .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
        .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_o(cs_o)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    always @(negedge clk) cyc++;

    // serial peripheral model
    bit          slv_on = 1'b0;
    bit          slv_cpha;
    int          slv_k, slv_idx, t_first, t_last;
    logic [31:0] slv_word, slv_cap;

    always @(sclk_o) begin
        if (slv_on) begin
            if (slv_k == 0) t_first = cyc;
            t_last = cyc;
            if ((slv_k % 2) == int'(slv_cpha)) slv_cap = {slv_cap[30:0], mosi_o};
            else if (slv_k > 0 && slv_idx > 0) slv_idx--;
            miso_i = slv_word[slv_idx];
            slv_k++;
        end
    end

    function automatic logic [31:0] lmask(input int len);
        return (len >= 31) ? 32'hFFFF_FFFF : ((32'h1 << (len + 1)) - 32'h1);
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b1; bus_addr_i = a; bus_wdata_i = v;
        @(negedge clk);
        bus_req_i = 1'b0; bus_we_i = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_req_i = 1'b1; bus_we_i = 1'b0; bus_addr_i = a;
        @(negedge clk);
        bus_req_i = 1'b0;
        v = bus_rdata_o;
    endtask

    task automatic run_word(input int len, input bit cpol, input bit cpha,
                            input logic [31:0] txw, input logic [31:0] slvw,
                            input bit load, input bit dbl);
        logic [31:0] base, st;
        int n;
        base = 32'h9000_1800 | (32'(cpol) << 24) | (32'(cpha) << 21) | 32'(len[4:0]);
        wr(9'h000, base);
        repeat (3) @(negedge clk);
        slv_cpha = cpha; slv_k = 0; slv_idx = len; slv_word = slvw; slv_cap = '0;
        miso_i = slvw[len]; slv_on = 1'b1;
        if (load) wr(9'h100, txw);
        wr(9'h000, base | 32'h4000_0000);
        if (dbl) wr(9'h000, base | 32'h4000_0000);
        n = 0;
        do begin
            rd(9'h008, st);
            n++;
        end while (st[31] && n < 3000);
        slv_on = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v, txw, slvw;
        int len;
        bit cpol, cpha;
        void'($urandom(32'h5EED_0017));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(9'h008, v);
        check("R1 status", v, 32'h00A0_0000);
        check("R1 cs", {30'b0, cs_o}, 32'h3);
        check("R1 sclk", {31'b0, sclk_o}, 32'h0);

        // R2 register map
        wr(9'h000, 32'hBFFF_FFFF);
        rd(9'h000, v); check("R2 cmd readback", v, 32'h9320_381F);
        wr(9'h004, 32'hFFFF_FFFF);
        rd(9'h004, v); check("R2 cmd2 readback", v, 32'hC00E_0000);
        rd(9'h00C, v); check("R2 reserved 0C", v, 32'h0);
        rd(9'h010, v); check("R2 offset 10", v, 32'h0);
        rd(9'h01C, v); check("R2 offset 1C", v, 32'h0);
        wr(9'h000, 32'h0);

        // R11 chip select
        wr(9'h004, 32'hC000_0000);
        wr(9'h000, 32'h0000_1800);
        check("R11 sel0 pol0", {30'b0, cs_o}, 32'h2);
        wr(9'h004, 32'hC004_0000);
        check("R11 sel1 pol0", {30'b0, cs_o}, 32'h1);
        wr(9'h000, 32'h0000_3800);
        check("R11 sel1 pol1", {30'b0, cs_o}, 32'h2);
        wr(9'h000, 32'h0000_0800);
        check("R11 value off", {30'b0, cs_o}, 32'h3);
        wr(9'h004, 32'hC000_0000);

        // R3 R4 R5: directed lengths then random words
        for (int i = 0; i < 26; i++) begin
            case (i)
                0: len = 7;  1: len = 15; 2: len = 23; 3: len = 31; 4: len = 0;
                default: len = int'($urandom_range(31, 0));
            endcase
            cpol = (i < 5) ? i[0] : 1'($urandom);
            cpha = (i < 5) ? i[1] : 1'($urandom);
            txw  = $urandom; slvw = $urandom;
            run_word(len, cpol, cpha, txw, slvw, 1'b1, 1'b0);
            check($sformatf("R4 mosi len%0d ph%0d", len + 1, cpha), slv_cap & lmask(len), txw & lmask(len));
            check("R3 sclk edges", 32'(slv_k), 32'(2 * (len + 1)));
            check("R3 sclk spacing", 32'(t_last - t_first), 32'((2 * len + 1) * (DIV_N + 1)));
            check("R3 sclk idle", {31'b0, sclk_o}, {31'b0, cpol});
            rd(9'h008, v);
            check("R5 bsy rdy txempty", v & 32'hC020_0000, 32'h4020_0000);
            rd(9'h180, v);
            check($sformatf("R4 rx len%0d ph%0d", len + 1, cpha), v, slvw & lmask(len));
            wr(9'h008, 32'h4000_0000);
            rd(9'h000, v); check("R2 go reads 0", {31'b0, v[30]}, 32'h0);
        end

        // R6 start while busy, R9 underrun, R7 W1C
        run_word(31, 1'b0, 1'b0, 32'h1234_5678, 32'hCAFE_F00D, 1'b1, 1'b1);
        check("R6 one word only", 32'(slv_k), 32'd64);
        rd(9'h180, v); check("R6 rx word", v, 32'hCAFE_F00D);
        rd(9'h180, v); check("R9 empty read", v, 32'h0);
        rd(9'h008, v); check("R6 R9 err rxunr", v & 32'h2004_0000, 32'h2004_0000);
        wr(9'h008, 32'h0);
        rd(9'h008, v); check("R7 write0 keeps", v & 32'h2004_0000, 32'h2004_0000);
        wr(9'h008, 32'h6004_0000);
        rd(9'h008, v); check("R7 w1c clears", v & 32'h6004_0000, 32'h0);

        // R8 TX overflow, R10 TX flush
        for (int i = 0; i < 4; i++) wr(9'h100, 32'(i));
        rd(9'h008, v); check("R8 full at 4", v & 32'h0018_0000, 32'h0010_0000);
        wr(9'h100, 32'hDEAD);
        rd(9'h008, v); check("R8 overflow", v & 32'h0008_0000, 32'h0008_0000);
        wr(9'h008, 32'h0408_0000);
        rd(9'h008, v); check("R10 tx flush", v & 32'h0438_0000, 32'h0020_0000);

        // R12 empty TX with transmit on
        run_word(15, 1'b1, 1'b1, 32'h0, 32'h00BE, 1'b0, 1'b0);
        check("R12 zeros out", slv_cap & 32'hFFFF, 32'h0);
        rd(9'h008, v); check("R12 tx underrun", v & 32'h0100_0000, 32'h0100_0000);
        rd(9'h180, v); check("R12 rx still pushed", v, 32'h00BE);
        wr(9'h008, 32'h4100_0000);

        // R13 transmit off / receive off
        wr(9'h004, 32'h8000_0000);
        run_word(7, 1'b0, 1'b1, 32'hA5, 32'h3C, 1'b1, 1'b0);
        check("R13 tx off zeros", slv_cap & 32'hFF, 32'h0);
        rd(9'h008, v); check("R13 tx fifo kept", v & 32'h0120_0000, 32'h0);
        rd(9'h180, v); check("R13 rx on", v, 32'h3C);
        wr(9'h004, 32'h4000_0000);
        run_word(7, 1'b0, 1'b0, 32'h0, 32'h77, 1'b0, 1'b0);
        check("R13 queued word sent", slv_cap & 32'hFF, 32'hA5);
        rd(9'h008, v); check("R13 rx off no push", v & 32'h0080_0000, 32'h0080_0000);
        wr(9'h004, 32'hC000_0000);
        wr(9'h008, 32'h4000_0000);

        // R12 RX overflow, R10 RX flush
        for (int i = 0; i < 5; i++) run_word(3, 1'b0, 1'b0, 32'(i), 32'(i + 8), 1'b1, 1'b0);
        rd(9'h008, v); check("R12 rx full ovf", v & 32'h0240_0000, 32'h0240_0000);
        rd(9'h180, v); check("R12 oldest kept", v, 32'h8);
        wr(9'h008, 32'h0800_0000);
        rd(9'h008, v); check("R10 rx flush", v & 32'h08C0_0000, 32'h0080_0000);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule